// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the scan timing for a passive-matrix (STN) or active-matrix (TFT) LCD panel from a set of programmable counts. It runs on the pixel clock. A pixel counter steps across each line and a line counter steps down each frame. From these two counters the block derives a one-clock line pulse, a frame pulse that covers the first line of every frame, and a display-enable window. It also drives a polarity-alternation signal that toggles once per frame or after a programmed number of line pulses.

Each timing count is sampled into a shadow copy at the last pixel of every frame, and once during reset. A frame therefore always runs on one consistent set of values. In TFT mode the horizontal and vertical start offsets move the active window away from the line and frame origin. In STN mode both offsets are treated as zero. A registered error flag reports when the live settings break the panel rules.

Top module: `lcd_raster_timing`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `pix_cnt` and `line_cnt` are 0 and `mod_out` is low.
- R2: With HT = `ht_cnt`+1, `pix_cnt` counts 0 to HT-1 and then returns to 0. `line_cnt` advances by one at each such wrap. With VT = `vt_cnt`+1, `line_cnt` returns to 0 after line VT-1.
- R3: `line_pulse` is high exactly in the cycles where `pix_cnt` is 0, which gives one pixel clock per line.
- R4: `frame_pulse` is high exactly in the cycles where `line_cnt` is 0, which covers the whole of line 0.
- R5: In TFT mode (`tft_mode`=1), `disp_en` is high only when two conditions hold together. The pixel count must lie in [HS, HS+HDP), with HS = `hdps_cnt`+1 and HDP = `hdp_cnt`+1. The line count must lie in [VS, VS+VDP), with VS = `vdps_cnt` and VDP = `vdp_cnt`+1.
- R6: In STN mode (`tft_mode`=0), HS and VS are both taken as 0, whatever `hdps_cnt` and `vdps_cnt` hold.
- R7: With a `mod_rate` of 0, `mod_out` inverts in the cycle after each cycle in which `pix_cnt` and `line_cnt` are both 0, and at no other time.
- R8: With a `mod_rate` of N > 0, `mod_out` inverts in the cycle after every Nth line pulse, without regard to frame boundaries. The count of line pulses starts at reset.
- R9: All the counts and `tft_mode` take effect only at the wrap from the last pixel of the last line to pixel 0 of line 0. A change made in mid-frame leaves the current frame unchanged.
- R10: `cfg_err` is a registered flag: each cycle it takes the value of the live inputs as they stood one clock earlier. It is high when VT <= VDP + VS or HT <= HDP + HS, where HS and VS follow the rules of R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| tft_mode | input | 1 | 1 = TFT (offsets apply), 0 = STN |
| ht_cnt | input | 10 | Total pixels per line minus one |
| vt_cnt | input | 10 | Total lines per frame minus one |
| hdp_cnt | input | 10 | Active pixels per line minus one |
| vdp_cnt | input | 10 | Active lines per frame minus one |
| hdps_cnt | input | 10 | TFT horizontal start offset minus one |
| vdps_cnt | input | 10 | TFT vertical start offset in lines |
| mod_rate | input | 6 | 0 = toggle per frame, N = toggle every N line pulses |
| line_pulse | output | 1 | One-clock pulse at the start of each line |
| frame_pulse | output | 1 | High during line 0 |
| disp_en | output | 1 | Active-area window |
| mod_out | output | 1 | Polarity alternation signal |
| pix_cnt | output | 10 | Current pixel position in the line |
| line_cnt | output | 10 | Current line in the frame |
| cfg_err | output | 1 | Live settings break the panel rules |

## Verification
The assertions assume that reset is held for at least one clock before any check applies. They also assume the shadow counts are fixed in value between frame boundaries. The line-pulse property further assumes a line longer than one pixel. Every configuration the stimulus latches has a total length of at least a few pixels, so each line holds a single pulse. The stimulus changes the inputs only on the falling clock edge. Some of those changes fall in the middle of a frame so that the deferred latching is exercised. Deliberately illegal settings are applied only briefly, to observe the error flag. The counters keep their defined wrap behaviour even then.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    parameter int CW = 10;
    parameter int MW = 6;
    localparam int SW = CW + 2;

    typedef struct packed {
        logic          tft;
        logic [CW-1:0] ht;
        logic [CW-1:0] vt;
        logic [CW-1:0] hdp;
        logic [CW-1:0] vdp;
        logic [CW-1:0] hdps;
        logic [CW-1:0] vdps;
        logic [MW-1:0] rate;
    } lcdt_cfg_t;

    // first active pixel; zero in STN mode
    function automatic logic [SW-1:0] h_start(input lcdt_cfg_t c);
        return c.tft ? SW'(c.hdps) + SW'(1) : '0;
    endfunction

    // first active line; zero in STN mode
    function automatic logic [SW-1:0] v_start(input lcdt_cfg_t c);
        return c.tft ? SW'(c.vdps) : '0;
    endfunction

    // rule check written in "count" form: total-1 <= active-1 + start
    function automatic logic cfg_bad(input lcdt_cfg_t c);
        logic hb, vb;
        hb = SW'(c.ht) <= SW'(c.hdp) + h_start(c);
        vb = SW'(c.vt) <= SW'(c.vdp) + v_start(c);
        return hb | vb;
    endfunction

endpackage

// File: rtl/lcdt_cfg_shadow.sv
module lcdt_cfg_shadow
    import lcdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      frame_end,
    input  lcdt_cfg_t cfg_in,
    output lcdt_cfg_t cfg_q,
    output logic      cfg_err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= cfg_in;
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= cfg_bad(cfg_in);
            if (frame_end) cfg_q <= cfg_in;
        end
    end

    // R9: shadow settings move only at a frame boundary
    p_hold_mid_frame_r9: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(cfg_q));

endmodule

// File: rtl/lcdt_raster.sv
module lcdt_raster
    import lcdt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  lcdt_cfg_t     cfg,
    output logic [CW-1:0] pix,
    output logic [CW-1:0] line,
    output logic          frame_end,
    output logic          line_pulse,
    output logic          frame_pulse,
    output logic          disp_en
);

    logic          line_end;
    logic [SW-1:0] hs, he, vs, ve;

    assign line_end  = (pix == cfg.ht);
    assign frame_end = line_end && (line == cfg.vt);

    always_ff @(posedge clk) begin
        if (rst) begin
            pix  <= '0;
            line <= '0;
        end else if (line_end) begin
            pix  <= '0;
            line <= (line == cfg.vt) ? '0 : line + 1'b1;
        end else begin
            pix <= pix + 1'b1;
        end
    end

    always_comb begin
        hs = h_start(cfg);
        vs = v_start(cfg);
        he = hs + SW'(cfg.hdp) + SW'(1);
        ve = vs + SW'(cfg.vdp) + SW'(1);
    end

    assign line_pulse  = (pix == '0);
    assign frame_pulse = (line == '0);
    assign disp_en     = (SW'(pix) >= hs) && (SW'(pix) < he) &&
                         (SW'(line) >= vs) && (SW'(line) < ve);

    // R2: counter steps by one until the programmed end, then wraps
    p_pix_step_r2: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> (pix == $past(pix) + 1'b1));
    p_pix_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        line_end |=> (pix == '0));
    // R3: a pulse never lasts two clocks on a line longer than one pixel
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        (line_pulse && cfg.ht != '0) |=> !line_pulse);
    // R4: frame pulse holds for the whole of line 0
    p_frame_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (frame_pulse && !line_end) |=> frame_pulse);

endmodule

// File: rtl/lcdt_mod_gen.sv
module lcdt_mod_gen
    import lcdt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          line_pulse,
    input  logic          frame_pulse,
    input  logic [MW-1:0] rate,
    output logic          mod_out
);

    logic [MW-1:0] lcnt;
    logic [MW:0]   lnext;
    logic          flip;

    assign lnext = {1'b0, lcnt} + 1'b1;

    always_comb begin
        if (rate == '0) flip = line_pulse && frame_pulse;
        else            flip = line_pulse && (lnext >= {1'b0, rate});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mod_out <= 1'b0;
            lcnt    <= '0;
        end else begin
            if (flip) mod_out <= ~mod_out;
            if (line_pulse && rate != '0)
                lcnt <= flip ? '0 : lnext[MW-1:0];
        end
    end

    // R7 R8: polarity only moves after a line pulse
    p_mod_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !line_pulse |=> $stable(mod_out));

endmodule

// File: rtl/lcd_raster_timing.sv
module lcd_raster_timing
    import lcdt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tft_mode,
    input  logic [9:0]    ht_cnt,
    input  logic [9:0]    vt_cnt,
    input  logic [9:0]    hdp_cnt,
    input  logic [9:0]    vdp_cnt,
    input  logic [9:0]    hdps_cnt,
    input  logic [9:0]    vdps_cnt,
    input  logic [5:0]    mod_rate,
    output logic          line_pulse,
    output logic          frame_pulse,
    output logic          disp_en,
    output logic          mod_out,
    output logic [9:0]    pix_cnt,
    output logic [9:0]    line_cnt,
    output logic          cfg_err
);

    lcdt_cfg_t cfg_live, cfg_sh;
    logic      frame_end;

    assign cfg_live = '{tft: tft_mode, ht: ht_cnt, vt: vt_cnt, hdp: hdp_cnt,
                        vdp: vdp_cnt, hdps: hdps_cnt, vdps: vdps_cnt,
                        rate: mod_rate};

    lcdt_cfg_shadow u_shadow (
        .clk       (clk),
        .rst       (rst),
        .frame_end (frame_end),
        .cfg_in    (cfg_live),
        .cfg_q     (cfg_sh),
        .cfg_err   (cfg_err)
    );

    lcdt_raster u_raster (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg_sh),
        .pix         (pix_cnt),
        .line        (line_cnt),
        .frame_end   (frame_end),
        .line_pulse  (line_pulse),
        .frame_pulse (frame_pulse),
        .disp_en     (disp_en)
    );

    lcdt_mod_gen u_mod (
        .clk         (clk),
        .rst         (rst),
        .line_pulse  (line_pulse),
        .frame_pulse (frame_pulse),
        .rate        (cfg_sh.rate),
        .mod_out     (mod_out)
    );

    // R1: reset clears the position and the polarity
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (pix_cnt == '0 && line_cnt == '0 && !mod_out));

endmodule

// File: tb/test_lcd_raster_timing.sv
module test_lcd_raster_timing;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tft_mode;
    logic [9:0] ht_cnt, vt_cnt, hdp_cnt, vdp_cnt, hdps_cnt, vdps_cnt;
    logic [5:0] mod_rate;
    logic       line_pulse, frame_pulse, disp_en, mod_out, cfg_err;
    logic [9:0] pix_cnt, line_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    lcd_raster_timing i_lcd_raster_timing (
        .clk(clk), .rst(rst), .tft_mode(tft_mode),
        .ht_cnt(ht_cnt), .vt_cnt(vt_cnt), .hdp_cnt(hdp_cnt), .vdp_cnt(vdp_cnt),
        .hdps_cnt(hdps_cnt), .vdps_cnt(vdps_cnt), .mod_rate(mod_rate),
        .line_pulse(line_pulse), .frame_pulse(frame_pulse), .disp_en(disp_en),
        .mod_out(mod_out), .pix_cnt(pix_cnt), .line_cnt(line_cnt), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic [9:0] pix;
        logic [9:0] line;
        logic lp, fp, de, md, er;
    } exp_t;

    exp_t q[$];

    // reference state, in "real" units (totals, not counts)
    int mh, mv, mlc;
    bit mmod, merr;
    int s_tft, s_ht, s_vt, s_hdp, s_vdp, s_hs, s_vs, s_rate;

    task automatic take_shadow();
        s_tft  = tft_mode;
        s_ht   = ht_cnt + 1;
        s_vt   = vt_cnt + 1;
        s_hdp  = hdp_cnt + 1;
        s_vdp  = vdp_cnt + 1;
        s_hs   = tft_mode ? hdps_cnt + 1 : 0;
        s_vs   = tft_mode ? vdps_cnt : 0;
        s_rate = mod_rate;
    endtask

    function automatic bit rules_broken();
        int hs, vs;
        hs = tft_mode ? hdps_cnt + 1 : 0;
        vs = tft_mode ? vdps_cnt : 0;
        return ((vt_cnt + 1) <= (vdp_cnt + 1) + vs) ||
               ((ht_cnt + 1) <= (hdp_cnt + 1) + hs);
    endfunction

    // driver side: predict the state after every edge and queue it
    always @(posedge clk) begin
        exp_t e;
        if (rst) begin
            mh = 0; mv = 0; mlc = 0; mmod = 0; merr = 0;
            take_shadow();
        end else begin
            merr = rules_broken();
            if (mh == 0) begin
                if (s_rate == 0) begin
                    if (mv == 0) mmod = ~mmod;
                end else if (mlc + 1 >= s_rate) begin
                    mmod = ~mmod; mlc = 0;
                end else begin
                    mlc = mlc + 1;
                end
            end
            if (mh == s_ht - 1) begin
                mh = 0;
                if (mv == s_vt - 1) begin mv = 0; take_shadow(); end
                else mv = mv + 1;
            end else begin
                mh = mh + 1;
            end
        end
        e.pix  = 10'(mh);
        e.line = 10'(mv);
        e.lp   = (mh == 0);
        e.fp   = (mv == 0);
        e.de   = (mh >= s_hs) && (mh < s_hs + s_hdp) &&
                 (mv >= s_vs) && (mv < s_vs + s_vdp);
        e.md   = mmod;
        e.er   = merr;
        q.push_back(e);
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    // monitor side: compare away from the active edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(pix_cnt == e.pix,      "R2 R9 pix",   pix_cnt,     e.pix);
            check(line_cnt == e.line,    "R2 R9 line",  line_cnt,    e.line);
            check(line_pulse == e.lp,    "R3 line_pulse", line_pulse, e.lp);
            check(frame_pulse == e.fp,   "R4 frame_pulse", frame_pulse, e.fp);
            check(disp_en == e.de,       "R5 R6 disp_en", disp_en,   e.de);
            check(mod_out == e.md,       "R7 R8 mod_out", mod_out,   e.md);
            check(cfg_err == e.er,       "R10 cfg_err", cfg_err,     e.er);
        end
    end

    task automatic set_cfg(input bit t, input int ht, input int vt, input int hdp,
                           input int vdp, input int hs, input int vs, input int rt);
        tft_mode = t;
        ht_cnt = 10'(ht); vt_cnt = 10'(vt); hdp_cnt = 10'(hdp); vdp_cnt = 10'(vdp);
        hdps_cnt = 10'(hs); vdps_cnt = 10'(vs); mod_rate = 6'(rt);
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // TFT: HT 20, VT 12, HDP 10, HS 4, VDP 6, VS 2, MOD per frame
        set_cfg(1, 19, 11, 9, 5, 3, 2, 0);
        run(3);
        check(pix_cnt == 0 && line_cnt == 0, "R1 counters in reset", pix_cnt, 0);
        check(mod_out == 0, "R1 mod in reset", mod_out, 0);
        rst = 1'b0;
        run(1);
        check(pix_cnt == 1 && line_cnt == 0, "R1 R2 first step", pix_cnt, 1);
        run(720);
        // mid-frame change to line-count MOD rate and a longer line (R8 R9)
        run(37);
        set_cfg(1, 23, 11, 9, 5, 3, 2, 5);
        run(900);
        // STN: offsets ignored (R6), MOD every line (R8)
        set_cfg(0, 19, 9, 15, 7, 300, 300, 1);
        run(800);
        // R10: vertical rule broken in TFT, fine in STN
        set_cfg(1, 19, 7, 9, 5, 3, 2, 3);
        run(2);
        check(cfg_err == 1, "R10 vertical rule tft", cfg_err, 1);
        set_cfg(0, 19, 7, 9, 5, 3, 2, 3);
        run(2);
        check(cfg_err == 0, "R10 same in stn", cfg_err, 0);
        // R10: horizontal rule broken, HT 14 <= HDP 10 + HS 4
        set_cfg(1, 13, 11, 9, 5, 3, 2, 3);
        run(2);
        check(cfg_err == 1, "R10 horizontal rule", cfg_err, 1);
        // R10: STN with VT equal to VDP
        set_cfg(0, 19, 5, 9, 5, 0, 0, 3);
        run(2);
        check(cfg_err == 1, "R10 vt equal vdp stn", cfg_err, 1);
        // legal again, long run with large rate spanning frames
        set_cfg(1, 15, 9, 7, 4, 2, 3, 13);
        run(1200);
        // reset in mid-frame
        rst = 1'b1;
        run(2);
        check(pix_cnt == 0 && line_cnt == 0 && mod_out == 0, "R1 mid-run reset", pix_cnt, 0);
        rst = 1'b0;
        run(300);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule